// File: doc/BRIEF.md
# Conversion Sequencing Controller for a Successive-Approximation Converter

This block is the digital sequencer that sits beside a successive-approximation converter. Software programs it over a small register bus with four locations: a control/status register holding the channel field, the continuous-mode bit and the interrupt enable; a clock configuration register holding the divider select, the resolution mode and the trigger-source select; and a high and a low result byte. A conversion starts either from a control/status write or from a rising edge on the hardware trigger input. Each conversion lasts a fixed number of divided clock periods. When that count runs out, the value on the digital sample input is captured as the conversion result.

When a result is ready it is moved into the result byte pair, the completion flag is set, and the interrupt line is raised if interrupts are enabled. In 10-bit mode, reading the high byte locks the pair until the low byte is read. A result that arrives while the pair is locked is discarded and the block immediately starts another conversion, even in single mode. Writing the control/status register, writing the clock configuration register, or a reset cancels any conversion in flight. A channel field of all ones parks the converter.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A conversion completes exactly CONV_CYC×2^sel clock cycles after the edge that starts it, where sel is clock-configuration bits [1:0] (factor 1, 2, 4 or 8).
- R2: In 10-bit mode (clock-configuration bit 2 = 1) the high result byte holds sample[9:8] in bits [1:0] with zeros above, and the low byte holds sample[7:0]. In 8-bit mode the high byte reads 0 and the low byte holds sample[9:2].
- R3: With hardware triggering off (clock-configuration bit 3 = 0), a control/status write whose channel field (bits [4:0]) is not all ones starts a conversion. A write with the channel field all ones starts none and stops any running conversion.
- R4: With hardware triggering on, a rising edge on hw_trig starts a conversion and restarts one already running. A control/status write then starts nothing.
- R5: With continuous mode set (control/status bit 5), each transferred result is followed at once by a new conversion of the same length.
- R6: A result transfer sets the completion flag (status read bit 7) and, if the interrupt enable (control/status bit 6) is set, raises irq in the same cycle. irq is never high while the flag is clear.
- R7: Reading the low result byte clears the flag and irq. A control/status write that starts a conversion also clears them.
- R8: In 10-bit mode, after the high byte has been read and before the low byte is read, a finished result is discarded: the result bytes do not change, the flag stays clear, and a new conversion starts whatever the continuous setting.
- R9: A control/status write or a clock-configuration write cancels the conversion in progress, so no result from it appears.
- R10: After reset, irq is 0, bus_rdata is 0, the status reads 0x1F (channel parked), and the clock configuration and both result bytes read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | 0 control/status, 1 clock config, 2 result high, 3 result low |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, valid the cycle after the read strobe |
| hw_trig | input | 1 | Hardware trigger, rising edge is the event |
| sample_in | input | 10 | Digital sample captured when a conversion ends |
| irq | output | 1 | Interrupt request, registered |

## Verification
The bus strobes, the trigger edge and the conversion start all act on the same clock edge, so a result is due exactly CONV_CYC×2^sel edges after that start edge, and irq and the flag change on that edge. The bench counts edges from the start edge and samples irq at falling edges just before and just at that due edge, which pins the latency to one cycle. Read data appears on the edge after the read strobe and is captured at the next falling edge. In the locked-pair case the first result would be due after CONV_CYC edges and the relaunched one after 2×CONV_CYC edges, and the bench checks both instants.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_CLK  = 2'd1,
    RA_RHI  = 2'd2,
    RA_RLO  = 2'd3
  } reg_addr_e;

  localparam int CTRL_CONT_BIT = 5;
  localparam int CTRL_IE_BIT   = 6;
  localparam int CLK_MODE_BIT  = 2;
  localparam int CLK_HW_BIT    = 3;
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim  = CNT_W'((32'd1 << sel) - 32'd1);
  assign tick = (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (tick)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int CONV_CYC = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic abort,
  input  logic tick,
  input  logic relaunch,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (CONV_CYC > 1) ? $clog2(CONV_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign busy = busy_q;
  assign done = busy_q && tick && (cnt_q == LAST) && !start && !abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (abort) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q && tick) begin
      if (cnt_q == LAST) begin
        busy_q <= relaunch;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done,
  input  logic [RES_W-1:0] sample,
  input  logic             mode10,
  input  logic             ie,
  input  logic             rd_hi,
  input  logic             rd_lo,
  input  logic             flag_clr,
  input  logic             lock_clr,
  output logic [7:0]       res_hi,
  output logic [7:0]       res_lo,
  output logic             flag,
  output logic             lock,
  output logic             irq
);
  localparam int HI_W = RES_W - 8;

  logic xfer;
  assign xfer = done && !lock;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_hi <= '0;
      res_lo <= '0;
    end else if (xfer) begin
      if (mode10) begin
        res_hi <= {{(8-HI_W){1'b0}}, sample[RES_W-1:8]};
        res_lo <= sample[7:0];
      end else begin
        res_hi <= '0;
        res_lo <= sample[RES_W-1:RES_W-8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else if (xfer) begin
      flag <= 1'b1;
      irq  <= ie;
    end else if (rd_lo || flag_clr) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || rd_lo || lock_clr) lock <= 1'b0;
    else if (rd_hi && mode10)     lock <= 1'b1;
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CH_W     = 5,
  parameter int RES_W    = 10,
  parameter int DIV_W    = 2,
  parameter int CONV_CYC = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             hw_trig,
  input  logic [RES_W-1:0] sample_in,
  output logic             irq
);
  localparam logic [CH_W-1:0] CH_OFF = '1;

  logic [CH_W-1:0]  chan_q;
  logic             cont_q, ie_q;
  logic [DIV_W-1:0] div_q;
  logic             mode10_q, hwsel_q;
  logic             trig_q;

  logic             ctrl_wr, clk_wr, rd_hi, rd_lo;
  logic [CH_W-1:0]  chan_nx;
  logic             trig_rise, sw_start, hw_start, start, abort;
  logic             tick, busy, done_evt, relaunch;
  logic [7:0]       res_hi, res_lo;
  logic             flag, lock;

  assign ctrl_wr   = bus_wr && (bus_addr == RA_CTRL);
  assign clk_wr    = bus_wr && (bus_addr == RA_CLK);
  assign rd_hi     = bus_rd && (bus_addr == RA_RHI);
  assign rd_lo     = bus_rd && (bus_addr == RA_RLO);
  assign chan_nx   = ctrl_wr ? bus_wdata[CH_W-1:0] : chan_q;
  assign trig_rise = hw_trig && !trig_q;
  assign sw_start  = ctrl_wr && !hwsel_q && (bus_wdata[CH_W-1:0] != CH_OFF);
  assign hw_start  = hwsel_q && trig_rise && (chan_nx != CH_OFF);
  assign start     = !clk_wr && (sw_start || hw_start);
  assign abort     = ctrl_wr || clk_wr;
  assign relaunch  = cont_q || lock;

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_q   <= CH_OFF;
      cont_q   <= 1'b0;
      ie_q     <= 1'b0;
      div_q    <= '0;
      mode10_q <= 1'b0;
      hwsel_q  <= 1'b0;
      trig_q   <= 1'b0;
    end else begin
      trig_q <= hw_trig;
      if (ctrl_wr) begin
        chan_q <= bus_wdata[CH_W-1:0];
        cont_q <= bus_wdata[CTRL_CONT_BIT];
        ie_q   <= bus_wdata[CTRL_IE_BIT];
      end
      if (clk_wr) begin
        div_q    <= bus_wdata[DIV_W-1:0];
        mode10_q <= bus_wdata[CLK_MODE_BIT];
        hwsel_q  <= bus_wdata[CLK_HW_BIT];
      end
    end
  end

  adc_clk_div #(.SEL_W(DIV_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .clr  (start || !busy),
    .sel  (div_q),
    .tick (tick)
  );

  adc_conv_timer #(.CONV_CYC(CONV_CYC)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .abort    (abort),
    .tick     (tick),
    .relaunch (relaunch),
    .busy     (busy),
    .done     (done_evt)
  );

  adc_result_bank #(.RES_W(RES_W)) u_res (
    .clk      (clk),
    .rst      (rst),
    .done     (done_evt),
    .sample   (sample_in),
    .mode10   (mode10_q),
    .ie       (ie_q),
    .rd_hi    (rd_hi),
    .rd_lo    (rd_lo),
    .flag_clr (sw_start && !clk_wr),
    .lock_clr (clk_wr),
    .res_hi   (res_hi),
    .res_lo   (res_lo),
    .flag     (flag),
    .lock     (lock),
    .irq      (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      unique case (bus_addr)
        RA_CTRL: bus_rdata <= 8'({flag, ie_q, cont_q, chan_q});
        RA_CLK:  bus_rdata <= 8'({hwsel_q, mode10_q, div_q});
        RA_RHI:  bus_rdata <= res_hi;
        RA_RLO:  bus_rdata <= res_lo;
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       irq,
  input logic       busy,
  input logic       flag,
  input logic       lock,
  input logic       cont_q,
  input logic       done_evt,
  input logic [7:0] res_hi,
  input logic [7:0] res_lo
);
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag); // R6

  AST_PARK_STOPS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd0 && bus_wdata[4:0] == 5'h1F) |=> !busy); // R3

  AST_CONT_RELAUNCH: assert property (@(posedge clk) disable iff (rst)
    (done_evt && cont_q) |=> busy); // R5

  AST_RDLO_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd3 && !done_evt) |=> !flag); // R7

  AST_BLOCK_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
    (done_evt && lock) |=> ($stable(res_hi) && $stable(res_lo))); // R8

  AST_BLOCK_RELAUNCH: assert property (@(posedge clk) disable iff (rst)
    (done_evt && lock) |=> busy); // R8

  AST_CLKWR_ABORTS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd1) |=> !busy); // R9
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .irq      (irq),
  .busy     (busy),
  .flag     (flag),
  .lock     (lock),
  .cont_q   (cont_q),
  .done_evt (done_evt),
  .res_hi   (res_hi),
  .res_lo   (res_lo)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  localparam int N = 12;

  logic       clk = 1'b0;
  logic       rst;
  logic       bus_wr, bus_rd;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       hw_trig;
  logic [9:0] sample_in;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  adc_seq_ctrl #(.CONV_CYC(N)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_trig(hw_trig), .sample_in(sample_in), .irq(irq)
  );

  function automatic logic [7:0] exp_hi(logic [9:0] s, logic m10);
    return m10 ? {6'd0, s[9:8]} : 8'd0;
  endfunction

  function automatic logic [7:0] exp_lo(logic [9:0] s, logic m10);
    return m10 ? s[7:0] : s[9:2];
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    cyc(1);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    cyc(1);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic pulse_trig();
    hw_trig = 1'b1;
    cyc(1);
    hw_trig = 1'b0;
  endtask

  // after a start edge, irq must be low one edge early and high on the due edge
  task automatic due(int d, string req);
    cyc(N*d - 1);
    chk(req, 16'(irq), 16'd0);
    cyc(1);
    chk(req, 16'(irq), 16'd1);
  endtask

  task automatic check_result(logic [9:0] s, logic m10, string req);
    logic [7:0] h, l;
    rd(2'd2, h);
    rd(2'd3, l);
    chk(req, 16'(h), 16'(exp_hi(s, m10)));
    chk(req, 16'(l), 16'(exp_lo(s, m10)));
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5EED1));
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    hw_trig = 0; sample_in = 0;
    cyc(3);
    rst = 1'b0;
    cyc(1);

    // R10 reset state
    chk("R10", 16'(irq), 16'd0);
    chk("R10", 16'(bus_rdata), 16'd0);
    rd(2'd0, d); chk("R10", 16'(d), 16'h1F);
    rd(2'd1, d); chk("R10", 16'(d), 16'h00);
    rd(2'd2, d); chk("R10", 16'(d), 16'h00);
    rd(2'd3, d); chk("R10", 16'(d), 16'h00);

    // R1 R2 R6 R7 random single conversions across dividers and modes
    for (int i = 0; i < 24; i++) begin
      logic [1:0] sel;
      logic m10;
      logic [4:0] ch;
      logic [9:0] s;
      sel = 2'($urandom_range(0, 3));
      m10 = 1'(i % 2);
      ch  = 5'($urandom_range(0, 30));
      s   = 10'($urandom);
      sample_in = s;
      wr(2'd1, {5'd0, m10, sel});
      wr(2'd0, {1'b0, 1'b1, 1'b0, ch});
      due(1 << sel, "R1");
      rd(2'd0, d); chk("R6", 16'(d[7]), 16'd1);
      check_result(s, m10, "R2");
      chk("R7", 16'(irq), 16'd0);
      rd(2'd0, d); chk("R7", 16'(d[7]), 16'd0);
    end

    // R3 parked channel starts nothing
    wr(2'd1, 8'h04);
    wr(2'd0, 8'h5F);
    cyc(3*N);
    chk("R3", 16'(irq), 16'd0);

    // R9 clock write cancels a running conversion
    wr(2'd0, 8'h43);
    cyc(3);
    wr(2'd1, 8'h04);
    cyc(3*N);
    chk("R9", 16'(irq), 16'd0);

    // R9 control write cancels and restarts; first result would be due at N
    sample_in = 10'h2A5;
    wr(2'd0, 8'h43);
    cyc(3);
    sample_in = 10'h15A;
    wr(2'd0, 8'h43);
    due(1, "R9");
    check_result(10'h15A, 1'b1, "R9");

    // R5 continuous mode
    sample_in = 10'h3C3;
    wr(2'd0, 8'h62);
    due(1, "R5");
    sample_in = 10'h0F0;
    rd(2'd3, d);
    chk("R7", 16'(irq), 16'd0);
    cyc(N - 2);
    chk("R5", 16'(irq), 16'd0);
    cyc(1);
    chk("R5", 16'(irq), 16'd1);
    wr(2'd0, 8'h5F);
    check_result(10'h0F0, 1'b1, "R5");
    cyc(3*N);
    chk("R3", 16'(irq), 16'd0);

    // R8 blocked transfer with relaunch in single mode
    sample_in = 10'h1E7;
    wr(2'd0, 8'h41);
    due(1, "R8");
    rd(2'd2, d);
    chk("R8", 16'(d), 16'(exp_hi(10'h1E7, 1'b1)));
    sample_in = 10'h2B4;
    wr(2'd0, 8'h41);
    cyc(N);
    chk("R8", 16'(irq), 16'd0);
    rd(2'd0, d); chk("R8", 16'(d[7]), 16'd0);
    rd(2'd3, d); chk("R8", 16'(d), 16'(exp_lo(10'h1E7, 1'b1)));
    cyc(N - 3);
    chk("R8", 16'(irq), 16'd0);
    cyc(1);
    chk("R8", 16'(irq), 16'd1);
    check_result(10'h2B4, 1'b1, "R8");

    // R4 hardware trigger mode
    wr(2'd1, 8'h0C);
    sample_in = 10'h333;
    wr(2'd0, 8'h44);
    cyc(3*N);
    chk("R4", 16'(irq), 16'd0);
    pulse_trig();
    cyc(3);
    pulse_trig();
    due(1, "R4");
    check_result(10'h333, 1'b1, "R4");
    wr(2'd1, 8'h02);
    wr(2'd1, 8'h0A);
    sample_in = 10'h0C7;
    pulse_trig();
    due(4, "R4");
    check_result(10'h0C7, 1'b0, "R4");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule